// File: doc/BRIEF.md
# March Memory Self-Test Controller

This block is a built-in self-test sequencer for a synchronous single-port RAM of 256 words by 8 bits. It drives the RAM's address, write-enable and write-data pins and watches its read data. It runs a reduced four-element march test in a fixed order:

1. A fill that writes all-zeros to every address.
2. An ascending pass that reads zero and then writes all-ones.
3. A descending pass that reads ones and then writes zero.
4. An ascending pass that reads zero to verify.

Every read is compared with the expected background. The address of each mismatching read is reported on a one-cycle failure strobe.

A rising edge on the start input launches a run. The done flag is low while the run is in progress and goes high at the end. The sticky fail flag then tells whether any mismatch was seen. A new start edge after completion clears both flags and repeats the whole test. The RAM has a one-cycle read latency. For this reason each read-modify address takes two cycles: a read cycle, then a cycle that compares the returned word and issues the write to the same address.

Top module: `march_bist_ctrl`

## Requirements
- R1: The run has exactly four elements in this order: fill, ascending read-zero/write-ones, descending read-ones/write-zero, ascending read-zero. Written data is only ever all-zeros (00h) or all-ones (FFh).
- R2: The fill and both ascending elements visit addresses 0 to 255 in rising order. The descending element visits addresses 255 down to 0.
- R3: In the read-modify elements, an address is read with write-enable low in one cycle. In the next cycle, the same address is written while the returned word is compared.
- R4: A compared word that differs from the expected background raises err_valid_o for exactly one cycle, on the clock edge after the compare cycle. err_addr_o carries the failing address in that cycle.
- R5: fail_o goes high with the first mismatch of a run and stays high until the next launch or reset. At completion it is high exactly when at least one mismatch occurred.
- R6: done_o is low for the whole run and goes high on the edge after the last compare. No memory write occurs while done_o is high or while the block is idle.
- R7: A start edge after completion clears done_o and fail_o and reruns the full test from address 0.
- R8: Only a low-to-high transition of start_i launches a run. Holding start_i high does not retrigger after completion, and a start edge during a run is ignored.
- R9: A synchronous active-low reset returns the block to idle at any time. After the reset, done_o, fail_o, err_valid_o and mem_we_o are low.
- R10: A full run takes 1792 cycles from launch to done: 256 cycles for the fill and 512 cycles for each of the other three elements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request; its rising edge launches a run |
| mem_addr_o | output | 8 | RAM address |
| mem_we_o | output | 1 | RAM write enable (low means read) |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, valid one cycle after the address |
| done_o | output | 1 | Run complete |
| fail_o | output | 1 | Sticky mismatch flag |
| err_valid_o | output | 1 | One-cycle failure strobe |
| err_addr_o | output | 8 | Failing address, valid with err_valid_o |

## Verification
The assertions assume that the RAM returns read data exactly one cycle after a read address and that start_i is a clean synchronous level. They also assume that reset is applied as whole clock cycles. The bench keeps to these assumptions: its behavioural RAM is registered with one-cycle latency, and it changes start_i and rst_n only on falling edges. Faults are injected as stuck bits inside that RAM, including at the boundary addresses 0 and 255. The mismatches therefore come from real reads, not from forced data.

// File: rtl/march_bist_pkg.sv
// Package: shared types for the march self-test controller.
// Assumes: four march elements, sequenced strictly in declaration order.
package march_bist_pkg;

    typedef enum logic [1:0] {
        EL_FILL0   = 2'd0,
        EL_UP_R0W1 = 2'd1,
        EL_DN_R1W0 = 2'd2,
        EL_UP_R0   = 2'd3
    } march_el_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_st_e;

endpackage

// File: rtl/march_addr_gen.sv
// Module: march_addr_gen
// Up/down address counter for the march sequencer. It can load the lowest
// or the highest address, or step by one in either direction.
// Assumes: at most one of the load/step controls is high per cycle; the
// loads take precedence when they are not.
module march_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [ADDR_W-1:0] addr,
    output logic              at_top,
    output logic              at_bot
);

    localparam logic [ADDR_W-1:0] ADDR_MIN = '0;
    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    // Address register: load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= ADDR_MIN;
        end else if (load_lo) begin
            addr <= ADDR_MIN;
        end else if (load_hi) begin
            addr <= ADDR_MAX;
        end else if (step_up) begin
            addr <= addr + ADDR_ONE;
        end else if (step_dn) begin
            addr <= addr - ADDR_ONE;
        end
    end

    assign at_top = (addr == ADDR_MAX);
    assign at_bot = (addr == ADDR_MIN);

endmodule

// File: rtl/march_seq.sv
// Module: march_seq
// March element sequencer. It detects the start edge, walks the four
// elements, and issues the RAM write controls plus the compare enable and
// the expected word. A read-modify address takes two cycles: a read in
// phase 0, then in phase 1 a compare of the returned word and a write.
// Assumes: RAM read latency of exactly one cycle; address counter external.
module march_seq
    import march_bist_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              at_top,
    input  logic              at_bot,
    output logic              launch_o,
    output logic              load_lo_o,
    output logic              load_hi_o,
    output logic              step_up_o,
    output logic              step_dn_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              chk_en_o,
    output logic [DATA_W-1:0] chk_exp_o,
    output logic              done_o
);

    localparam logic [DATA_W-1:0] BG_ZERO = '0;
    localparam logic [DATA_W-1:0] BG_ONE  = '1;

    ctl_st_e   state;
    march_el_e el;
    logic      phase;
    logic      start_q;
    logic      slot_end;
    logic      el_last;

    // Previous start level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= start_i;
        end
    end

    assign launch_o = start_i & ~start_q & (state != ST_RUN);
    assign el_last  = (el == EL_DN_R1W0) ? at_bot : at_top;

    // Per-cycle RAM controls and compare request for the current element.
    always_comb begin
        slot_end    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = BG_ZERO;
        chk_en_o    = 1'b0;
        chk_exp_o   = BG_ZERO;
        if (state == ST_RUN) begin
            case (el)
                EL_FILL0: begin
                    mem_we_o = 1'b1;
                    slot_end = 1'b1;
                end
                EL_UP_R0W1: begin
                    if (phase) begin
                        mem_we_o    = 1'b1;
                        mem_wdata_o = BG_ONE;
                        chk_en_o    = 1'b1;
                        slot_end    = 1'b1;
                    end
                end
                EL_DN_R1W0: begin
                    if (phase) begin
                        mem_we_o  = 1'b1;
                        chk_en_o  = 1'b1;
                        chk_exp_o = BG_ONE;
                        slot_end  = 1'b1;
                    end
                end
                default: begin
                    if (phase) begin
                        chk_en_o = 1'b1;
                        slot_end = 1'b1;
                    end
                end
            endcase
        end
    end

    // Address counter controls at the end of each address slot.
    assign load_lo_o = launch_o |
                       (slot_end & el_last & ((el == EL_FILL0) | (el == EL_DN_R1W0)));
    assign load_hi_o = slot_end & el_last & (el == EL_UP_R0W1);
    assign step_up_o = slot_end & ~el_last & (el != EL_DN_R1W0);
    assign step_dn_o = slot_end & ~el_last & (el == EL_DN_R1W0);

    // Control state: launch, element advance, phase toggle and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            el     <= EL_FILL0;
            phase  <= 1'b0;
            done_o <= 1'b0;
        end else if (launch_o) begin
            state  <= ST_RUN;
            el     <= EL_FILL0;
            phase  <= 1'b0;
            done_o <= 1'b0;
        end else if (state == ST_RUN) begin
            if (el != EL_FILL0) begin
                phase <= ~phase;
            end
            if (slot_end && el_last) begin
                if (el == EL_UP_R0) begin
                    state  <= ST_DONE;
                    done_o <= 1'b1;
                end else begin
                    el <= march_el_e'(el + 2'd1);
                end
            end
        end
    end

endmodule

// File: rtl/march_cmp.sv
// Module: march_cmp
// Read-data comparator. It registers a one-cycle failure strobe with the
// failing address and keeps the sticky fail flag.
// Assumes: chk_en is high only in the cycle where rdata holds the word
// read from addr; clear is the launch pulse.
module march_cmp #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              chk_en,
    input  logic [DATA_W-1:0] chk_exp,
    input  logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] addr,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    output logic              fail
);

    logic mism;

    assign mism = chk_en & (rdata != chk_exp);

    // Failure strobe, captured address and sticky fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_addr  <= '0;
            fail      <= 1'b0;
        end else begin
            err_valid <= mism;
            if (mism) begin
                err_addr <= addr;
            end
            if (clear) begin
                fail <= 1'b0;
            end else if (mism) begin
                fail <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/march_bist_ctrl.sv
// Module: march_bist_ctrl (top)
// March self-test controller for a single-port synchronous RAM. It
// connects the sequencer, the address counter and the comparator.
// Assumes: the RAM returns read data one cycle after the address with the
// write enable low; the RAM itself sits outside this block.
module march_bist_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic              fail_o,
    output logic              err_valid_o,
    output logic [ADDR_W-1:0] err_addr_o
);

    logic              launch;
    logic              load_lo;
    logic              load_hi;
    logic              step_up;
    logic              step_dn;
    logic              at_top;
    logic              at_bot;
    logic              chk_en;
    logic [DATA_W-1:0] chk_exp;

    march_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .at_top      (at_top),
        .at_bot      (at_bot),
        .launch_o    (launch),
        .load_lo_o   (load_lo),
        .load_hi_o   (load_hi),
        .step_up_o   (step_up),
        .step_dn_o   (step_dn),
        .mem_we_o    (mem_we_o),
        .mem_wdata_o (mem_wdata_o),
        .chk_en_o    (chk_en),
        .chk_exp_o   (chk_exp),
        .done_o      (done_o)
    );

    march_addr_gen #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .step_up (step_up),
        .step_dn (step_dn),
        .addr    (mem_addr_o),
        .at_top  (at_top),
        .at_bot  (at_bot)
    );

    march_cmp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .chk_en    (chk_en),
        .chk_exp   (chk_exp),
        .rdata     (mem_rdata_i),
        .addr      (mem_addr_o),
        .err_valid (err_valid_o),
        .err_addr  (err_addr_o),
        .fail      (fail_o)
    );

endmodule

// File: rtl/march_bist_chk.sv
// Module: march_bist_chk
// Property checker for march_bist_ctrl, attached with bind below.
// Assumes: the one-cycle RAM read latency of the controller.
module march_bist_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_we_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              done_o,
    input logic              fail_o,
    input logic              err_valid_o,
    input logic [ADDR_W-1:0] err_addr_o
);

    localparam logic [DATA_W-1:0] BG_ZERO = '0;
    localparam logic [DATA_W-1:0] BG_ONE  = '1;

    AST_WDATA_BACKGROUND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_wdata_o == BG_ZERO || mem_wdata_o == BG_ONE)); // R1

    AST_FILL_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R2

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_wdata_o == BG_ONE) |-> (!$past(mem_we_o) && $past(mem_addr_o) == mem_addr_o)); // R3

    AST_STROBE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid_o |-> ($past(!mem_we_o, 2) && $past(mem_addr_o, 2) == err_addr_o)); // R4

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid_o |=> !err_valid_o); // R4

    AST_FAIL_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid_o |-> fail_o); // R5

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_we_o); // R6

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R8

endmodule

bind march_bist_ctrl march_bist_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .err_valid_o (err_valid_o),
    .err_addr_o  (err_addr_o)
);

// File: tb/test_march_bist_ctrl.sv
// Bench for march_bist_ctrl: a behavioural RAM with stuck-bit injection, and
// a queue of expected operations compared against the design on every clock.
`timescale 1ns/1ps
module test_march_bist_ctrl;

    typedef struct packed {
        logic [7:0] addr;
        logic       we;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] ex;
    } op_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic       done;
    logic       fail;
    logic       err_valid;
    logic [7:0] err_addr;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    logic [7:0] ram     [256];
    logic [7:0] ref_mem [256];
    logic [7:0] smask   [256];
    logic [7:0] sval    [256];
    op_t        opq[$];

    always #10 clk = ~clk;

    march_bist_ctrl i_march_bist_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mem_addr_o  (mem_addr),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .done_o      (done),
        .fail_o      (fail),
        .err_valid_o (err_valid),
        .err_addr_o  (err_addr)
    );

    function automatic logic [7:0] flt(input logic [7:0] a, input logic [7:0] d);
        return (d & ~smask[a]) | (sval[a] & smask[a]);
    endfunction

    // Behavioural RAM, one-cycle read latency, stuck bits applied on write.
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= flt(mem_addr, mem_wdata);
        mem_rdata <= ram[mem_addr];
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            nchk++;
            $display("FAIL R10 watchdog: got %0d cycles expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic op_t mk(input int a, input bit we, input logic [7:0] wd,
                               input bit chk, input logic [7:0] ex);
        op_t o;
        o.addr = a[7:0];
        o.we   = we;
        o.wd   = wd;
        o.chk  = chk;
        o.ex   = ex;
        return o;
    endfunction

    task automatic build_ops();
        opq.delete();
        for (int a = 0; a < 256; a++) opq.push_back(mk(a, 1, 8'h00, 0, 8'h00));
        for (int a = 0; a < 256; a++) begin
            opq.push_back(mk(a, 0, 8'h00, 0, 8'h00));
            opq.push_back(mk(a, 1, 8'hFF, 1, 8'h00));
        end
        for (int a = 255; a >= 0; a--) begin
            opq.push_back(mk(a, 0, 8'h00, 0, 8'h00));
            opq.push_back(mk(a, 1, 8'h00, 1, 8'hFF));
        end
        for (int a = 0; a < 256; a++) begin
            opq.push_back(mk(a, 0, 8'h00, 0, 8'h00));
            opq.push_back(mk(a, 0, 8'h00, 1, 8'h00));
        end
    endtask

    task automatic clear_faults();
        for (int a = 0; a < 256; a++) begin
            smask[a] = 8'h00;
            sval[a]  = 8'h00;
        end
    endtask

    task automatic set_faults();
        smask[0]   = 8'h08; sval[0]   = 8'h08;
        smask[5]   = 8'h01; sval[5]   = 8'h01;
        smask[255] = 8'h80; sval[255] = 8'h00;
    endtask

    // One full run, compared cycle by cycle with the expected operation queue.
    task automatic run_test(input bit hold_start, input int poke_at,
                            output int steps, output int strobes, output bit end_fail);
        op_t        op;
        bit         pend;
        logic [7:0] pend_addr;
        bit         exp_fail;
        bit         finished;
        build_ops();
        steps = 0; strobes = 0; pend = 0; pend_addr = 8'h00;
        exp_fail = 0; finished = 0;
        @(negedge clk);
        start_i = 1'b1;
        for (int k = 0; k < 4000 && !finished; k++) begin
            @(negedge clk);
            if (!hold_start) start_i = (poke_at > 0 && steps == poke_at) ? 1'b1 : 1'b0;
            check(err_valid == pend, "R4", "err_valid", err_valid, pend);
            if (pend) begin
                check(err_addr == pend_addr, "R4", "err_addr", err_addr, pend_addr);
                exp_fail = 1;
            end
            if (err_valid) strobes++;
            pend = 0;
            check(fail == exp_fail, "R5", "fail sticky", fail, exp_fail);
            if (opq.size() > 0) begin
                op = opq.pop_front();
                steps++;
                check(done == 1'b0, "R6", "done during run", done, 0);
                check(mem_addr == op.addr, "R2", "address order", mem_addr, op.addr);
                check(mem_we == op.we, "R3", "write enable", mem_we, op.we);
                if (op.we) check(mem_wdata == op.wd, "R1", "write data", mem_wdata, op.wd);
                if (op.chk) begin
                    pend = (ref_mem[op.addr] != op.ex);
                    pend_addr = op.addr;
                end
                if (op.we) ref_mem[op.addr] = flt(op.addr, op.wd);
            end else begin
                check(done == 1'b1, "R6", "done at completion", done, 1);
                finished = 1;
            end
        end
        check(finished, "R6", "run finished", finished, 1);
        end_fail = fail;
    endtask

    int  st;
    int  sb;
    bit  ef;

    initial begin
        for (int a = 0; a < 256; a++) begin
            ram[a]     = 8'(a * 37 + 11);
            ref_mem[a] = 8'(a * 37 + 11);
        end
        clear_faults();
        repeat (3) @(negedge clk);
        check(done == 0 && fail == 0 && err_valid == 0 && mem_we == 0, "R9",
              "reset state", {done, fail, err_valid, mem_we}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 0 && mem_we == 0, "R9", "idle after reset", {done, mem_we}, 0);

        // Clean memory
        run_test(0, 0, st, sb, ef);
        check(st == 1792, "R10", "run length", st, 1792);
        check(sb == 0, "R4", "no strobes on clean memory", sb, 0);
        check(ef == 0, "R5", "clean fail flag", ef, 0);

        // Stuck bits at addresses 0, 5 and 255
        set_faults();
        run_test(0, 0, st, sb, ef);
        check(sb == 5, "R4", "strobe count with faults", sb, 5);
        check(ef == 1, "R5", "fail flag with faults", ef, 1);
        check(st == 1792, "R1", "element sequence length", st, 1792);

        // Rerun on clean memory with a start edge mid-run
        clear_faults();
        run_test(0, 700, st, sb, ef);
        check(ef == 0, "R7", "fail cleared on rerun", ef, 0);
        check(st == 1792, "R8", "mid-run start ignored", st, 1792);

        // Start held high across completion
        set_faults();
        run_test(1, 0, st, sb, ef);
        check(ef == 1, "R7", "fail set again", ef, 1);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(done == 1 && mem_we == 0, "R8", "held start no retrigger",
                  {done, mem_we}, 2'b10);
        end
        start_i = 1'b0;

        // Reset in the middle of a run
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (400) @(negedge clk);
        check(fail == 1 && done == 0, "R5", "fail raised mid-run", {fail, done}, 2'b10);
        rst_n = 1'b0;
        @(negedge clk);
        check(done == 0 && fail == 0 && err_valid == 0 && mem_we == 0, "R9",
              "mid-run reset", {done, fail, err_valid, mem_we}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(mem_we == 0 && done == 0, "R9", "stays idle after reset", {mem_we, done}, 0);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule